// File: doc/BRIEF.md
# Configurable Index Word Unpacker

This block sits between a command FIFO and the vertex fetch logic of a geometry front end. A job is set up by loading an index count and a 2-bit index-type code. Words of 32 bits then arrive from the FIFO, and the block splits each word into one, two or four vertex indices. It presents them one at a time on a valid/ready output, each zero-extended to the full word width.

The lanes of a word are taken starting from the least significant bits. When the loaded count runs out partway through a word, that word is still taken from the FIFO and its unused upper lanes are thrown away. The next job begins on a fresh word. There is no internal word buffer. A word is taken from the input in the same cycle that its last needed index is taken at the output, so a stalled consumer stalls the FIFO. One cycle after the final index of a job is taken, a one-cycle completion pulse is raised.

Top module: `idx_unpacker`

## Requirements
- R1: With type code 0, each input word gives exactly one index, equal to the whole 32-bit word.
- R2: With type code 1, each word gives two indices: bits 15:0 first, then bits 31:16, each zero-extended to 32 bits.
- R3: With type code 2, each word gives four indices: bits 7:0, 15:8, 23:16 and 31:24, in that order, each zero-extended to 32 bits.
- R4: Type code 3 is reserved and behaves exactly like type code 0.
- R5: When the count ends partway through a word, that word is still taken and its remaining lanes are discarded. For example, three 8-bit indices use one word and drop its top byte. The next job starts at lane 0 of a new word.
- R6: out_valid is high only while indices of a loaded job remain and in_valid is high. After reset, out_valid, in_ready and done are low. Loading a count of zero produces no output and no done pulse.
- R7: in_ready is high only in a cycle where an index is taken (out_valid and out_ready high) and that index is the last lane of the word or the last index of the job. While out_ready is low, no word is taken.
- R8: done is high for exactly one cycle, namely the cycle after the last index of a job is taken.
- R9: A load request (cfg_valid) that arrives while indices of a job remain is ignored.
- R10: The type code is captured at load time. Changing cfg_kind during a job has no effect on that job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Load request for a new job (taken only when idle) |
| cfg_kind | input | 2 | Index type code: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = reserved (as 0) |
| cfg_count | input | CNT_W | Number of indices in the job |
| in_valid | input | 1 | Input word available from the FIFO |
| in_data | input | WORD_W | Input word |
| in_ready | output | 1 | Input word is taken at this clock edge |
| out_valid | output | 1 | An index is presented |
| out_index | output | WORD_W | Current index, zero-extended |
| out_ready | input | 1 | Consumer takes the presented index |
| done | output | 1 | One-cycle pulse after the last index of a job |

## Verification
The bench aims at jobs whose counts end in the middle of a word. A design that fails to drop the leftover lanes would emit an extra index or keep a stale lane for the next job, so the scoreboard would see a surplus or shifted index and a wrong word tally. It drives a random output stall pattern and checks the input handshake at every taken index. A design that took words early or late would show in_ready in the wrong cycle and would consume the wrong number of words. It also sends a load request and a type change in the middle of a job. A design that reloaded or re-decoded would produce indices that disagree with the queued expectations. Finally, it checks the reserved code, a zero count and the timing of the done pulse: a misplaced or repeated pulse, or any output on an empty job, is flagged.

// File: rtl/idx_unpack_pkg.sv
package idx_unpack_pkg;

   typedef enum logic [1:0] {
      IDX_W32 = 2'd0,
      IDX_W16 = 2'd1,
      IDX_W8  = 2'd2,
      IDX_RSV = 2'd3
   } idx_kind_e;

   // Highest lane number used by a word of the given kind.
   function automatic logic [1:0] top_lane(input idx_kind_e k);
      case (k)
         IDX_W16: top_lane = 2'd1;
         IDX_W8:  top_lane = 2'd3;
         default: top_lane = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/idx_lane_sel.sv
module idx_lane_sel
   import idx_unpack_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  idx_kind_e           kind,
   input  logic [1:0]          lane,
   input  logic [WORD_W-1:0]   word,
   output logic [WORD_W-1:0]   idx
);
   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   logic [HALF_W-1:0] halves [2];
   logic [QTR_W-1:0]  quarters [4];

   for (genvar g = 0; g < 2; g++) begin : g_half
      assign halves[g] = word[g*HALF_W +: HALF_W];
   end
   for (genvar g = 0; g < 4; g++) begin : g_qtr
      assign quarters[g] = word[g*QTR_W +: QTR_W];
   end

   always_comb begin
      case (kind)
         IDX_W16: idx = WORD_W'(halves[lane[0]]);
         IDX_W8:  idx = WORD_W'(quarters[lane]);
         default: idx = word;
      endcase
   end

endmodule

// File: rtl/idx_count_track.sv
module idx_count_track
   import idx_unpack_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [1:0]       cfg_kind,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             fire,
   output logic             busy,
   output idx_kind_e        kind,
   output logic [1:0]       lane,
   output logic             word_end,
   output logic             done
);
   logic [CNT_W-1:0] remaining;
   logic             take_cfg;
   logic             last_idx;

   assign busy     = remaining != '0;
   assign take_cfg = cfg_valid && !busy;
   assign last_idx = remaining == CNT_W'(1);
   assign word_end = (lane == top_lane(kind)) || last_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remaining <= '0;
         kind      <= IDX_W32;
         lane      <= 2'd0;
         done      <= 1'b0;
      end else begin
         done <= fire && last_idx;
         if (take_cfg) begin
            remaining <= cfg_count;
            kind      <= idx_kind_e'(cfg_kind);
            lane      <= 2'd0;
         end else if (fire) begin
            remaining <= remaining - CNT_W'(1);
            lane      <= word_end ? 2'd0 : lane + 2'd1;
         end
      end
   end

   // R2 / R3: lane pointer never passes the last lane of the latched kind
   p_lane_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lane <= top_lane(kind));

   // R8: completion is a single-cycle pulse
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: a load during a job leaves the count to the normal decrement
   p_cfg_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && busy) |=>
         remaining == $past(remaining) - {{(CNT_W-1){1'b0}}, $past(fire)});

   // R10: latched kind does not move while a job is running
   p_kind_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(kind));

endmodule

// File: rtl/idx_unpacker.sv
module idx_unpacker
   import idx_unpack_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [1:0]        cfg_kind,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_index,
   input  logic              out_ready,
   output logic              done
);
   if (WORD_W < 8 || (WORD_W % 4) != 0) begin : g_bad_word
      $error("idx_unpacker: WORD_W must be a multiple of 4 and at least 8");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("idx_unpacker: CNT_W must be at least 1");
   end

   logic      busy;
   logic      fire;
   logic      word_end;
   idx_kind_e kind;
   logic [1:0] lane;

   assign out_valid = busy && in_valid;
   assign fire      = out_valid && out_ready;
   assign in_ready  = fire && word_end;

   idx_count_track #(.CNT_W(CNT_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_kind  (cfg_kind),
      .cfg_count (cfg_count),
      .fire      (fire),
      .busy      (busy),
      .kind      (kind),
      .lane      (lane),
      .word_end  (word_end),
      .done      (done)
   );

   idx_lane_sel #(.WORD_W(WORD_W)) u_sel (
      .kind (kind),
      .lane (lane),
      .word (in_data),
      .idx  (out_index)
   );

   // R7: a taken index that does not close its word leaves work pending
   p_mid_word_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !in_ready) |=> busy);

   // R8: the completion cycle presents no index
   p_quiet_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);

   // R6: no word is taken while idle
   p_idle_no_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !in_ready);

endmodule

// File: tb/idx_unpacker_tb.sv
`timescale 1ns/1ps
module idx_unpacker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [1:0]  cfg_kind = 2'd0;
   logic [15:0] cfg_count = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_index;
   logic        out_ready = 1'b1;
   logic        done;

   always #2 clk = ~clk;

   idx_unpacker #(.WORD_W(32), .CNT_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_kind(cfg_kind),
      .cfg_count(cfg_count), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_index(out_index),
      .out_ready(out_ready), .done(done)
   );

   int tests = 0;
   int failed = 0;
   logic [31:0] expq[$];
   int  m_left = 0, m_lane = 0, m_lanes = 1, words_taken = 0;
   bit  exp_done_next = 1'b0;
   bit  stall = 1'b0;
   string cur_tag = "R6";
   logic [31:0] wseed = 32'h1357_9bdf;
   logic [15:0] lfsr = 16'hace1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // output stall pattern
   initial begin
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = stall ? lfsr[0] : 1'b1;
      end
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done || exp_done_next)
               check(done == exp_done_next, "R8", "done pulse", 32'(done), 32'(exp_done_next));
            exp_done_next = 1'b0;
            if (out_valid && out_ready) begin
               if (expq.size() == 0) begin
                  check(1'b0, "R6", "unexpected index", out_index, 32'h0);
               end else begin
                  logic [31:0] e;
                  bit pop_exp;
                  e = expq.pop_front();
                  check(out_index == e, cur_tag, "index value", out_index, e);
                  pop_exp = (m_lane == m_lanes - 1) || (m_left == 1);
                  check(in_ready == pop_exp, "R7", "word take timing", 32'(in_ready), 32'(pop_exp));
                  if (m_left == 1) exp_done_next = 1'b1;
                  m_left--;
                  m_lane = pop_exp ? 0 : m_lane + 1;
               end
            end else if (in_ready) begin
               check(1'b0, "R7", "word taken without index", 32'(in_ready), 32'h0);
            end
            if (in_valid && in_ready) words_taken++;
         end
      end
   end

   task automatic run_job(input logic [1:0] kind, input int count,
                          input string tag, input bit poke);
      int lanes, nw;
      logic [31:0] wq[$];
      lanes = (kind == 2'd1) ? 2 : (kind == 2'd2) ? 4 : 1;
      nw = (count + lanes - 1) / lanes;
      for (int w = 0; w < nw; w++) begin
         logic [31:0] word;
         wseed = wseed * 32'h9e37_79b9 + 32'h7f4a_7c15;
         word = wseed;
         wq.push_back(word);
         for (int l = 0; l < lanes; l++) begin
            if (w * lanes + l < count) begin
               if (lanes == 2)      expq.push_back({16'h0, word[l*16 +: 16]});
               else if (lanes == 4) expq.push_back({24'h0, word[l*8 +: 8]});
               else                 expq.push_back(word);
            end
         end
      end
      @(posedge clk); #1;
      cfg_valid = 1'b1; cfg_kind = kind; cfg_count = 16'(count);
      cur_tag = tag; m_left = count; m_lane = 0; m_lanes = lanes; words_taken = 0;
      @(posedge clk); #1;
      cfg_valid = 1'b0;
      if (poke) begin
         cfg_kind = kind ^ 2'b11;          // R10: change the type mid-job
         cfg_valid = 1'b1; cfg_count = 16'd9; // R9: load request while busy
         @(posedge clk); #1;
         cfg_valid = 1'b0;
      end
      if (count == 0) begin
         in_valid = 1'b1; in_data = 32'hdead_beef;
         repeat (6) begin
            @(negedge clk);
            check(!out_valid && !in_ready, "R6", "zero-count job idle",
                  {30'h0, out_valid, in_ready}, 32'h0);
         end
         @(posedge clk); #1;
         in_valid = 1'b0;
      end else begin
         foreach (wq[i]) begin
            in_valid = 1'b1; in_data = wq[i];
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
         end
         in_valid = 1'b0;
         in_data = 32'hffff_ffff;
      end
      repeat (3) @(negedge clk);
      check(words_taken == nw, tag, "words consumed", 32'(words_taken), 32'(nw));
      check(expq.size() == 0, tag, "indices left unsent", 32'(expq.size()), 32'h0);
      expq.delete();
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      in_valid = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      @(negedge clk);
      check(!out_valid && !in_ready && !done, "R6", "reset outputs",
            {29'h0, out_valid, in_ready, done}, 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      check(!out_valid && !in_ready && !done, "R6", "idle after reset",
            {29'h0, out_valid, in_ready, done}, 32'h0);

      run_job(2'd0, 5, "R1", 1'b0);
      run_job(2'd1, 6, "R2", 1'b0);
      run_job(2'd2, 8, "R3", 1'b0);
      run_job(2'd3, 3, "R4", 1'b0);
      run_job(2'd2, 3, "R5", 1'b0);   // one word, top byte dropped
      run_job(2'd0, 2, "R5", 1'b0);   // next job starts on a fresh word
      run_job(2'd1, 5, "R5", 1'b0);   // last upper half dropped
      run_job(2'd2, 6, "R5", 1'b0);
      stall = 1'b1;
      run_job(2'd2, 11, "R7", 1'b0);
      run_job(2'd1, 7, "R10", 1'b1);
      run_job(2'd2, 5, "R9", 1'b1);
      stall = 1'b0;
      run_job(2'd0, 0, "R6", 1'b0);
      run_job(2'd1, 1, "R8", 1'b0);

      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule